// File: doc/BRIEF.md
# Event Counter Bank with Sticky Overflow Status

The block keeps eight free-running 32-bit event counters, grouped as four pairs. Within a pair, one counter is the upper half and one the lower half of a 64-bit window. Each counter advances on its own event strobe. A single read/write port reaches one pair at a time, and a select field in the control register chooses which. Reads and writes always move both halves of that pair together.

When a counter steps from all ones to zero, it wraps. The wrap sets that counter's sticky bit in the control register's overflow field and pulses a level-15 interrupt request for one cycle. Software may rewrite the overflow field at any time to clear or set bits. A bit set this way never raises the interrupt.

A guard bit in the control register can lock the counter port against non-privileged code. While locked, such an access does three things: it changes nothing, it reads back zero, and it raises a one-cycle exception pulse. Control and status pins are plain level signals. The block has no data stream, so no valid/ready handshake is used.

Top module: `perf_ctr_bank`

## Requirements
- R1: After reset, every counter is zero, the overflow field is zero, the select field points at pair 0, the guard bit is clear, and `irq_l15` and `priv_exc` are low.
- R2: Each counter increments by one at every clock edge where its strobe is high. Strobe bit 2p drives the lower counter of pair p, and bit 2p+1 drives the upper counter.
- R3: While `ctr_rd_en` is high and access is granted, `ctr_rdata` shows the selected pair in the same cycle: upper counter on bits [63:32], lower counter on bits [31:0]. Pairs that are not selected are never changed by the port.
- R4: A granted `ctr_wr_en` loads both halves of the selected pair from `ctr_wdata` at one edge. If an event strobe hits the same counter in that cycle, the write wins and the strobe is dropped. A loaded value never counts as an overflow.
- R5: A counter at 0xFFFF_FFFF that gets a strobe becomes 0 and sets overflow bit i, where i is the counter's strobe index.
- R6: Counters that wrap at the same edge each set their own bit. A bit that is already set stays set if its counter wraps again.
- R7: A control write replaces the overflow field with the written bits, which clears or sets them. A hardware wrap at the same edge still leaves its bit set.
- R8: `irq_l15` is high for exactly the cycle after an edge at which at least one counter wrapped, and is low otherwise. Overflow bits set by software never raise it.
- R9: When the guard bit is set, a read or write with `acc_user` high is refused. A refused access loads nothing, reads as zero, and raises `priv_exc` for the following cycle. When `acc_user` is low, or the guard bit is clear, the access is granted.
- R10: `ctl_rdata`, and the control write data, use this layout: bits [7:0] are the overflow field, bits [9:8] are the select field, and bit 10 is the guard bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_strobe | input | 8 | One event strobe per counter |
| ctl_wr_en | input | 1 | Write the control register |
| ctl_wdata | input | 11 | Control write data (guard, select, overflow) |
| ctl_rdata | output | 11 | Current control register contents |
| ctr_rd_en | input | 1 | Read the selected pair |
| ctr_wr_en | input | 1 | Write the selected pair |
| acc_user | input | 1 | Access comes from non-privileged code |
| ctr_wdata | input | 64 | Pair write data: upper half, then lower half |
| ctr_rdata | output | 64 | Pair read data, zero if not granted |
| priv_exc | output | 1 | One-cycle pulse after a refused access |
| irq_l15 | output | 1 | One-cycle level-15 interrupt request after a wrap |

## Verification
Single strobes on one counter show that counting works and that the strobe-to-counter mapping is right. Preloading counters just below the wrap point shows that a true all-ones-to-zero step is told apart from a loaded value. Strobing several preloaded counters at once separates per-bit status from a single shared flag. Control writes that land on the same edge as a wrap, or alone, separate software status from hardware status and prove that the interrupt stays silent for software writes. A long random run mixes strobes, pair writes near the wrap point, selection changes and refused user accesses, and compares every cycle against a bench model.

// File: rtl/perf_ctr_pkg.sv
package perf_ctr_pkg;

  // outcome of a counter-port access request
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_GRANT = 2'd1,
    ACC_DENY  = 2'd2
  } acc_e;

  // interrupt level produced on hardware wrap
  localparam int unsigned IRQ_LEVEL = 15;

endpackage

// File: rtl/pc_counter.sv
module pc_counter #(
  parameter int CTR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CTR_W-1:0] load_val,
  input  logic             inc,
  output logic [CTR_W-1:0] cnt,
  output logic             wrap
);

  // load has priority over increment; a loaded value never wraps
  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (inc)  cnt <= cnt + 1'b1;
  end

  assign wrap = inc && !load && (&cnt);

endmodule

// File: rtl/pc_access.sv
module pc_access
  import perf_ctr_pkg::*;
#(
  parameter int NUM_PAIRS = 4,
  parameter int SEL_W     = 2
) (
  input  logic                 guard,
  input  logic                 acc_user,
  input  logic                 rd_en,
  input  logic                 wr_en,
  input  logic [SEL_W-1:0]     sel,
  output acc_e                 state,
  output logic                 rd_ok,
  output logic [NUM_PAIRS-1:0] wr_pair
);

  always_comb begin
    if (!(rd_en || wr_en))     state = ACC_IDLE;
    else if (guard && acc_user) state = ACC_DENY;
    else                        state = ACC_GRANT;
  end

  assign rd_ok = rd_en && (state == ACC_GRANT);

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_wsel
    assign wr_pair[p] = wr_en && (state == ACC_GRANT) && (sel == SEL_W'(p));
  end

endmodule

// File: rtl/pc_ctrl.sv
module pc_ctrl #(
  parameter int NCTR  = 8,
  parameter int SEL_W = 2,
  localparam int CTL_W = NCTR + SEL_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wdata,
  input  logic [NCTR-1:0]  hw_wrap,
  output logic [NCTR-1:0]  ovf,
  output logic [SEL_W-1:0] sel,
  output logic             guard,
  output logic             irq
);

  logic [NCTR-1:0] ovf_base;

  // software value replaces the field; hardware wraps are merged on top
  assign ovf_base = wr_en ? wdata[NCTR-1:0] : ovf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf   <= '0;
      sel   <= '0;
      guard <= 1'b0;
      irq   <= 1'b0;
    end else begin
      ovf <= ovf_base | hw_wrap;
      irq <= |hw_wrap;
      if (wr_en) begin
        sel   <= wdata[NCTR +: SEL_W];
        guard <= wdata[CTL_W-1];
      end
    end
  end

endmodule

// File: rtl/perf_ctr_bank.sv
module perf_ctr_bank
  import perf_ctr_pkg::*;
#(
  parameter int NUM_PAIRS = 4,
  parameter int CTR_W     = 32,
  localparam int NCTR  = 2 * NUM_PAIRS,
  localparam int SEL_W = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1,
  localparam int CTL_W = NCTR + SEL_W + 1,
  localparam int PAIR_W = 2 * CTR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCTR-1:0]   evt_strobe,
  input  logic              ctl_wr_en,
  input  logic [CTL_W-1:0]  ctl_wdata,
  output logic [CTL_W-1:0]  ctl_rdata,
  input  logic              ctr_rd_en,
  input  logic              ctr_wr_en,
  input  logic              acc_user,
  input  logic [PAIR_W-1:0] ctr_wdata,
  output logic [PAIR_W-1:0] ctr_rdata,
  output logic              priv_exc,
  output logic              irq_l15
);

  acc_e                   acc_state;
  logic                   rd_ok;
  logic [NUM_PAIRS-1:0]   wr_pair;
  logic [NCTR-1:0]        hw_wrap;
  logic [NCTR-1:0]        ovf_q;
  logic [SEL_W-1:0]       sel_q;
  logic                   priv_q;
  logic                   exc_q;
  logic [CTR_W-1:0]       cnt_arr [NCTR];
  logic [NCTR*CTR_W-1:0]  cnt_flat;

  pc_access #(
    .NUM_PAIRS (NUM_PAIRS),
    .SEL_W     (SEL_W)
  ) u_access (
    .guard    (priv_q),
    .acc_user (acc_user),
    .rd_en    (ctr_rd_en),
    .wr_en    (ctr_wr_en),
    .sel      (sel_q),
    .state    (acc_state),
    .rd_ok    (rd_ok),
    .wr_pair  (wr_pair)
  );

  // counter i belongs to pair i/2; odd index is the upper half
  for (genvar i = 0; i < NCTR; i++) begin : g_ctr
    pc_counter #(.CTR_W(CTR_W)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wr_pair[i/2]),
      .load_val (ctr_wdata[(i%2)*CTR_W +: CTR_W]),
      .inc      (evt_strobe[i]),
      .cnt      (cnt_arr[i]),
      .wrap     (hw_wrap[i])
    );
    assign cnt_flat[i*CTR_W +: CTR_W] = cnt_arr[i];
  end

  pc_ctrl #(
    .NCTR  (NCTR),
    .SEL_W (SEL_W)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ctl_wr_en),
    .wdata   (ctl_wdata),
    .hw_wrap (hw_wrap),
    .ovf     (ovf_q),
    .sel     (sel_q),
    .guard   (priv_q),
    .irq     (irq_l15)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) exc_q <= 1'b0;
    else        exc_q <= (acc_state == ACC_DENY);
  end

  assign priv_exc  = exc_q;
  assign ctl_rdata = {priv_q, sel_q, ovf_q};
  assign ctr_rdata = rd_ok ? {cnt_arr[{sel_q, 1'b1}], cnt_arr[{sel_q, 1'b0}]}
                           : '0;

endmodule

// File: rtl/perf_ctr_bank_chk.sv
module perf_ctr_bank_chk #(
  parameter int NCTR   = 8,
  parameter int CTR_W  = 32,
  parameter int PAIR_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCTR-1:0]   evt_strobe,
  input logic              ctl_wr_en,
  input logic              ctr_rd_en,
  input logic              ctr_wr_en,
  input logic              acc_user,
  input logic [PAIR_W-1:0] ctr_rdata,
  input logic              priv_exc,
  input logic              irq_l15,
  input logic [NCTR-1:0]   ovf_q,
  input logic              priv_q,
  input logic [NCTR*CTR_W-1:0] cnt_flat
);

  logic denied;
  assign denied = priv_q && acc_user && (ctr_rd_en || ctr_wr_en);

  AST_IRQ_HAS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_l15 |-> (ovf_q != '0)); // R8

  AST_NO_EVENT_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_strobe == '0) |=> !irq_l15); // R8

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr_en |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q))); // R6

  AST_DENY_RAISES_EXC: assert property (@(posedge clk) disable iff (!rst_n)
    denied |=> priv_exc); // R9

  AST_GRANT_NO_EXC: assert property (@(posedge clk) disable iff (!rst_n)
    !denied |=> !priv_exc); // R9

  AST_DENY_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (denied && evt_strobe == '0) |=> $stable(cnt_flat)); // R9

  AST_DENY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    denied |-> (ctr_rdata == '0)); // R9

endmodule

bind perf_ctr_bank perf_ctr_bank_chk #(
  .NCTR   (NCTR),
  .CTR_W  (CTR_W),
  .PAIR_W (PAIR_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .evt_strobe (evt_strobe),
  .ctl_wr_en  (ctl_wr_en),
  .ctr_rd_en  (ctr_rd_en),
  .ctr_wr_en  (ctr_wr_en),
  .acc_user   (acc_user),
  .ctr_rdata  (ctr_rdata),
  .priv_exc   (priv_exc),
  .irq_l15    (irq_l15),
  .ovf_q      (ovf_q),
  .priv_q     (priv_q),
  .cnt_flat   (cnt_flat)
);

// File: tb/perf_ctr_bank_tb_top.sv
`timescale 1ns/1ps
module perf_ctr_bank_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  evt_strobe = '0;
  logic        ctl_wr_en = 1'b0;
  logic [10:0] ctl_wdata = '0;
  logic [10:0] ctl_rdata;
  logic        ctr_rd_en = 1'b0;
  logic        ctr_wr_en = 1'b0;
  logic        acc_user = 1'b0;
  logic [63:0] ctr_wdata = '0;
  logic [63:0] ctr_rdata;
  logic        priv_exc;
  logic        irq_l15;

  always #2.5 clk = ~clk;

  perf_ctr_bank dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_strobe (evt_strobe),
    .ctl_wr_en  (ctl_wr_en),
    .ctl_wdata  (ctl_wdata),
    .ctl_rdata  (ctl_rdata),
    .ctr_rd_en  (ctr_rd_en),
    .ctr_wr_en  (ctr_wr_en),
    .acc_user   (acc_user),
    .ctr_wdata  (ctr_wdata),
    .ctr_rdata  (ctr_rdata),
    .priv_exc   (priv_exc),
    .irq_l15    (irq_l15)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [31:0] m_ctr [8];
  logic [7:0]  m_ovf;
  logic [1:0]  m_sel;
  logic        m_priv;

  function automatic logic [10:0] mk_ctl(logic g, logic [1:0] s, logic [7:0] o);
    return {g, s, o};
  endfunction

  function automatic logic [63:0] m_pair(logic [1:0] s);
    return {m_ctr[2*s+1], m_ctr[2*s]};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one clock cycle: drive at falling edge, predict, compare after rising edge
  task automatic cyc(string rtag, logic [7:0] evt, logic cwe, logic [10:0] cwd,
                     logic rd, logic wr, logic usr, logic [63:0] wd);
    logic        blk;
    logic [7:0]  hw;
    logic [31:0] nx [8];
    logic [7:0]  n_ovf;
    @(negedge clk);
    evt_strobe = evt; ctl_wr_en = cwe; ctl_wdata = cwd;
    ctr_rd_en = rd; ctr_wr_en = wr; acc_user = usr; ctr_wdata = wd;
    #1;
    blk = m_priv && usr && (rd || wr);
    if (rd) chk(rtag, ctr_rdata, blk ? 64'd0 : m_pair(m_sel));
    hw = '0;
    for (int i = 0; i < 8; i++) begin
      nx[i] = m_ctr[i];
      if (wr && !blk && (i/2) == int'(m_sel))
        nx[i] = (i % 2) ? wd[63:32] : wd[31:0];
      else if (evt[i]) begin
        if (m_ctr[i] == 32'hFFFF_FFFF) hw[i] = 1'b1;
        nx[i] = m_ctr[i] + 32'd1;
      end
    end
    n_ovf = (cwe ? cwd[7:0] : m_ovf) | hw;
    @(posedge clk);
    #1;
    for (int i = 0; i < 8; i++) m_ctr[i] = nx[i];
    m_ovf = n_ovf;
    if (cwe) begin m_sel = cwd[9:8]; m_priv = cwd[10]; end
    chk("R8 irq_l15", 64'(irq_l15), 64'(|hw));
    chk("R9 priv_exc", 64'(priv_exc), 64'(blk));
    chk("R10 ctl_rdata", 64'(ctl_rdata), 64'({m_priv, m_sel, m_ovf}));
  endtask

  task automatic idle();
    cyc("idle", '0, 0, '0, 0, 0, 0, '0);
  endtask

  task automatic sel_pair(logic [1:0] p);
    cyc("sel", '0, 1, mk_ctl(m_priv, p, m_ovf), 0, 0, 0, '0);
  endtask

  task automatic rd_pair(string tag, logic [1:0] p);
    sel_pair(p);
    cyc(tag, '0, 0, '0, 1, 0, 0, '0);
  endtask

  task automatic wr_pair(logic [1:0] p, logic [63:0] v);
    sel_pair(p);
    cyc("wr", '0, 0, '0, 0, 1, 0, v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0017));
    for (int i = 0; i < 8; i++) m_ctr[i] = '0;
    m_ovf = '0; m_sel = '0; m_priv = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1: reset state
    chk("R1 ctl_rdata", 64'(ctl_rdata), 64'd0);
    chk("R1 irq_l15", 64'(irq_l15), 64'd0);
    chk("R1 priv_exc", 64'(priv_exc), 64'd0);
    for (int p = 0; p < 4; p++) rd_pair("R1 pair zero", 2'(p));

    // R2: strobe mapping, lower=2p, upper=2p+1
    cyc("R2", 8'b0000_0001, 0, '0, 0, 0, 0, '0);
    cyc("R2", 8'b0000_0011, 0, '0, 0, 0, 0, '0);
    cyc("R2", 8'b1000_0100, 0, '0, 0, 0, 0, '0);
    rd_pair("R2 pair0 count", 2'd0);
    rd_pair("R2 pair1 count", 2'd1);
    rd_pair("R2 pair3 count", 2'd3);

    // R3/R4: write both halves, other pairs untouched; write beats strobe
    wr_pair(2'd2, 64'h1234_5678_9ABC_DEF0);
    rd_pair("R3 pair2 loaded", 2'd2);
    rd_pair("R3 pair0 untouched", 2'd0);
    sel_pair(2'd1);
    cyc("R4", 8'b0000_1100, 0, '0, 0, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF);
    cyc("R4 write wins", '0, 0, '0, 1, 0, 0, '0);

    // R5: wrap of pair1 lower (index 2) sets bit 2
    cyc("R5", 8'b0000_0100, 0, '0, 0, 0, 0, '0);
    rd_pair("R5 wrapped to zero", 2'd1);

    // R6: simultaneous wraps and re-wrap of a set bit
    wr_pair(2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    cyc("R6", 8'b1100_1000, 0, '0, 0, 0, 0, '0);
    wr_pair(2'd1, 64'hFFFF_FFFF_FFFF_FFFF);
    cyc("R6 rewrap", 8'b0000_0100, 0, '0, 0, 0, 0, '0);

    // R7: software clear/set, no irq; clear racing a hardware wrap
    cyc("R7 clear", '0, 1, mk_ctl(0, m_sel, 8'h00), 0, 0, 0, '0);
    cyc("R7 set", '0, 1, mk_ctl(0, m_sel, 8'h21), 0, 0, 0, '0);
    idle();
    wr_pair(2'd0, 64'h0000_0000_FFFF_FFFF);
    cyc("R7 race", 8'b0000_0001, 1, mk_ctl(0, 2'd0, 8'h00), 0, 0, 0, '0);

    // R9: guard set, user access refused, privileged access granted
    cyc("R9 guard", '0, 1, mk_ctl(1, 2'd2, m_ovf), 0, 0, 0, '0);
    cyc("R9 user write", '0, 0, '0, 0, 1, 1, 64'hDEAD_BEEF_0BAD_F00D);
    cyc("R9 user read", '0, 0, '0, 1, 0, 1, '0);
    cyc("R9 priv read", '0, 0, '0, 1, 0, 0, '0);
    cyc("R9 unguard", '0, 1, mk_ctl(0, 2'd2, m_ovf), 0, 0, 0, '0);
    cyc("R9 user read open", '0, 0, '0, 1, 0, 1, '0);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [7:0]  evt;
      logic        cwe, rd, wr, usr;
      logic [10:0] cwd;
      logic [63:0] wd;
      evt = 8'($urandom) & 8'($urandom);
      cwe = ($urandom % 8) == 0;
      cwd = mk_ctl(($urandom % 4) == 0, 2'($urandom), 8'($urandom));
      rd  = ($urandom % 3) == 0;
      wr  = ($urandom % 6) == 0;
      usr = ($urandom % 2) == 0;
      wd  = {32'hFFFF_FFFF - 32'($urandom % 4), 32'hFFFF_FFFF - 32'($urandom % 4)};
      cyc("R3 random read", evt, cwe, cwd, rd, wr, usr, wd);
    end
    cyc("R9 unlock", '0, 1, mk_ctl(0, 2'd0, m_ovf), 0, 0, 0, '0);
    for (int p = 0; p < 4; p++) rd_pair("R2 final pair", 2'(p));

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule